// File: doc/BRIEF.md
# I2C Master Burst Word Counter

This block sets the length of a burst on an I2C master and says when the burst is over. Software writes the number of data words into a 32-bit count register. The low 16 bits hold the count and the upper half always reads as zero. When the bus engine signals the start of a transfer, the programmed value is copied into a separate 17-bit down-counter. The register keeps the value software wrote. The engine then pulses a strobe for every data word that moves, and the direction of the transfer does not matter.

Counting only applies when the master input is high and the repeat input is low at the moment of the start pulse. These two mode inputs are captured at the start. A programmed value of zero means 65536 words. When the last word has moved, a done flag rises and stays high. If a STOP was requested when that last word moved, a request to the bus engine to issue a STOP condition rises with it. A new start pulse clears both flags and reloads the counter.

Top module: `xfer_count_ctrl`

## Requirements
- R1: Bits 31:16 of `reg_rdata` are always zero. Bits 31:16 of a write have no effect.
- R2: After reset the count field is 0. A cycle with `reg_we` high stores `reg_wdata[15:0]`, and the new value shows on `reg_rdata[15:0]` from the next cycle.
- R3: `xfer_start` loads `remaining` from the count field as it was before that edge. The field itself is only changed by a write, never by the countdown. A write during a burst does not change `remaining`.
- R4: A count field of 0 loads `remaining` with 65536.
- R5: While counting, each `word_done` cycle lowers `remaining` by exactly one, in either transfer direction.
- R6: Counting is enabled only if `mode_master`=1 and `mode_rpt`=0 in the start cycle. Otherwise `remaining` keeps its loaded value, and `count_done` and `stop_gen` stay low whatever strobes arrive.
- R7: The strobe that takes `remaining` from 1 to 0 sets `count_done` on the next cycle. On the same cycle it sets `stop_gen`, but only if `stop_req` is high together with that strobe.
- R8: `count_done` and `stop_gen` hold until the next start. Further strobes leave `remaining` at 0 with no wrap.
- R9: `xfer_start` clears `count_done` and `stop_gen` on the next cycle. A strobe in the same cycle as a start is ignored, because the start wins.
- R10: During and after reset, `remaining`, `count_done` and `stop_gen` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the count register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Count register read value |
| mode_master | input | 1 | Master mode, captured at start |
| mode_rpt | input | 1 | Repeat mode, captured at start; turns the count off |
| stop_req | input | 1 | STOP wanted at the end of the burst |
| xfer_start | input | 1 | Start of transfer, loads the down-counter |
| word_done | input | 1 | One data word moved |
| remaining | output | 17 | Words left in the burst |
| count_done | output | 1 | Countdown finished, held |
| stop_gen | output | 1 | Request to issue a STOP condition, held |

## Verification
The bench builds the block with its default widths: a 32-bit register and a 16-bit count field. At these widths the zero-means-65536 case can be run to the end. The bench sends 65536 back-to-back strobes and watches the counter come down from its top value through 1 to 0. It also watches it reach the flag edges without wrapping. All of this fits well inside the cycle budget.

// File: rtl/xcc_pkg.sv
package xcc_pkg;

    typedef struct packed {
        logic master;
        logic rpt;
    } mode_t;

    typedef struct packed {
        logic done;
        logic stop;
    } term_t;

endpackage

// File: rtl/xcc_count_reg.sv
module xcc_count_reg #(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] field,
    output logic [REG_W-1:0] rdata
);
    localparam int PAD_W = REG_W - CNT_W;

    typedef struct packed {
        logic [CNT_W-1:0] field;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.field = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign field = st_q.field;
    assign rdata = {{PAD_W{1'b0}}, st_q.field};

endmodule

// File: rtl/xcc_countdown.sv
module xcc_countdown #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             word,
    input  logic [CNT_W-1:0] field,
    input  xcc_pkg::mode_t   mode,
    output logic [CNT_W:0]   remaining,
    output logic             active,
    output logic             last_word
);
    localparam int REM_W = CNT_W + 1;
    localparam logic [REM_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
    localparam logic [REM_W-1:0] ONE      = {{CNT_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [REM_W-1:0] rem;
        logic             active;
    } cd_state_t;

    cd_state_t st_d, st_q;
    logic      step;

    assign step = st_q.active && word && !load;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.rem    = (field == '0) ? FULL_CNT : {1'b0, field};
            st_d.active = mode.master && !mode.rpt;
        end else if (step) begin
            st_d.rem = st_q.rem - ONE;
            if (st_q.rem == ONE) begin
                st_d.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign remaining = st_q.rem;
    assign active    = st_q.active;
    assign last_word = step && (st_q.rem == ONE);

endmodule

// File: rtl/xcc_term.sv
module xcc_term (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic last_word,
    input  logic stop_req,
    output logic done,
    output logic stop
);
    xcc_pkg::term_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d = '0;
        end else if (last_word) begin
            st_d.done = 1'b1;
            st_d.stop = stop_req;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done = st_q.done;
    assign stop = st_q.stop;

endmodule

// File: rtl/xfer_count_ctrl.sv
module xfer_count_ctrl #(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             mode_master,
    input  logic             mode_rpt,
    input  logic             stop_req,
    input  logic             xfer_start,
    input  logic             word_done,
    output logic [CNT_W:0]   remaining,
    output logic             count_done,
    output logic             stop_gen
);
    logic [CNT_W-1:0] cnt_field;
    logic             cnt_active;
    logic             last_word;
    logic             unused_wr_hi;
    xcc_pkg::mode_t   mode;

    assign unused_wr_hi = ^reg_wdata[REG_W-1:CNT_W];
    assign mode.master  = mode_master;
    assign mode.rpt     = mode_rpt;

    xcc_count_reg #(.REG_W(REG_W), .CNT_W(CNT_W)) u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wdata (reg_wdata[CNT_W-1:0]),
        .field (cnt_field),
        .rdata (reg_rdata)
    );

    xcc_countdown #(.CNT_W(CNT_W)) u_cd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (xfer_start),
        .word      (word_done),
        .field     (cnt_field),
        .mode      (mode),
        .remaining (remaining),
        .active    (cnt_active),
        .last_word (last_word)
    );

    xcc_term u_term (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (xfer_start),
        .last_word (last_word),
        .stop_req  (stop_req),
        .done      (count_done),
        .stop      (stop_gen)
    );

endmodule

// File: rtl/xcc_checker.sv
module xcc_checker #(
    parameter int REG_W = 32,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [REG_W-1:0] reg_wdata,
    input logic [REG_W-1:0] reg_rdata,
    input logic             xfer_start,
    input logic             word_done,
    input logic             cnt_active,
    input logic [CNT_W:0]   remaining,
    input logic             count_done,
    input logic             stop_gen
);
    localparam logic [CNT_W:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

    AST_REG_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> reg_rdata[CNT_W-1:0] == $past(reg_wdata[CNT_W-1:0])); // R2

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(reg_rdata)); // R3

    AST_ZERO_LOADS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && reg_rdata[CNT_W-1:0] == '0) |=> remaining == FULL_CNT); // R4

    AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_active && word_done && !xfer_start) |=> remaining == $past(remaining) - 1'b1); // R5

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_active && !xfer_start) |=> $stable(remaining)); // R8

    AST_STOP_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_gen |-> count_done); // R7

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> (!count_done && !stop_gen)); // R9

endmodule

bind xfer_count_ctrl xcc_checker #(.REG_W(REG_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .xfer_start (xfer_start),
    .word_done  (word_done),
    .cnt_active (cnt_active),
    .remaining  (remaining),
    .count_done (count_done),
    .stop_gen   (stop_gen)
);

// File: tb/tb_xfer_count_ctrl.sv
module tb_xfer_count_ctrl;
    localparam int REG_W = 32;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b1;
    logic             reg_we = 1'b0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             mode_master = 1'b0;
    logic             mode_rpt = 1'b0;
    logic             stop_req = 1'b0;
    logic             xfer_start = 1'b0;
    logic             word_done = 1'b0;
    logic [CNT_W:0]   remaining;
    logic             count_done;
    logic             stop_gen;

    int n_chk = 0;
    int n_fail = 0;
    bit cmp_on = 1'b0;
    bit finished = 1'b0;
    int cyc = 0;

    // behavioural reference state
    longint m_reg = 0;
    longint m_rem = 0;
    bit     m_act = 0;
    bit     m_done = 0;
    bit     m_stop = 0;

    always #2.5 clk = ~clk;

    xfer_count_ctrl #(.REG_W(REG_W), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mode_master(mode_master), .mode_rpt(mode_rpt),
        .stop_req(stop_req), .xfer_start(xfer_start), .word_done(word_done),
        .remaining(remaining), .count_done(count_done), .stop_gen(stop_gen)
    );

    task automatic chk(string req, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg = 0; m_rem = 0; m_act = 0; m_done = 0; m_stop = 0;
        end else begin
            if (xfer_start) begin
                m_rem  = (m_reg == 0) ? 65536 : m_reg;
                m_act  = mode_master && !mode_rpt;
                m_done = 0;
                m_stop = 0;
            end else if (word_done && m_act && m_rem > 0) begin
                m_rem = m_rem - 1;
                if (m_rem == 0) begin
                    m_act  = 0;
                    m_done = 1;
                    m_stop = stop_req;
                end
            end
            if (reg_we) m_reg = reg_wdata % 65536;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R1/R2 model rdata", reg_rdata, m_reg);
            chk("R5 model remaining", remaining, m_rem);
            chk("R7 model done", count_done, m_done);
            chk("R7 model stop", stop_gen, m_stop);
        end
    end

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            summary();
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(longint v);
        reg_we = 1'b1; reg_wdata = v[REG_W-1:0];
        tick();
        reg_we = 1'b0;
    endtask

    task automatic start(bit m, bit r, bit s);
        mode_master = m; mode_rpt = r; stop_req = s; xfer_start = 1'b1;
        tick();
        xfer_start = 1'b0;
    endtask

    task automatic words(int n, int gap);
        for (int i = 0; i < n; i++) begin
            word_done = 1'b1;
            tick();
            word_done = 1'b0;
            for (int g = 0; g < gap; g++) tick();
        end
    endtask

    initial begin
        #1 rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R10 reset remaining", remaining, 0);
        chk("R10 reset done", count_done, 0);
        chk("R10 reset stop", stop_gen, 0);
        chk("R2 reset field", reg_rdata, 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick();

        wr(64'hABCD_1234);
        chk("R1 upper bits read zero", reg_rdata, 32'h0000_1234);

        wr(5);
        start(1, 0, 1);
        chk("R3 load", remaining, 5);
        words(2, 1);
        chk("R5 decrement", remaining, 3);
        wr(9);
        chk("R3 write mid-burst leaves count", remaining, 3);
        words(3, 0);
        chk("R7 done", count_done, 1);
        chk("R7 stop", stop_gen, 1);
        chk("R3 field unchanged by countdown", reg_rdata, 9);
        words(3, 0);
        chk("R8 no wrap", remaining, 0);
        chk("R8 done held", count_done, 1);

        wr(3);
        start(1, 0, 0);
        chk("R9 start clears done", count_done, 0);
        words(3, 2);
        chk("R7 done without stop", count_done, 1);
        chk("R7 no stop when not requested", stop_gen, 0);

        wr(4);
        start(1, 1, 1);
        words(6, 0);
        chk("R6 repeat mode holds count", remaining, 4);
        chk("R6 repeat mode no done", count_done, 0);
        start(0, 0, 1);
        words(6, 0);
        chk("R6 slave holds count", remaining, 4);
        chk("R6 slave no stop", stop_gen, 0);

        mode_master = 1; mode_rpt = 0; stop_req = 1;
        xfer_start = 1'b1; word_done = 1'b1;
        tick();
        xfer_start = 1'b0; word_done = 1'b0;
        chk("R9 start beats strobe", remaining, 4);
        words(4, 0);
        chk("R9 then finishes", stop_gen, 1);

        wr(0);
        start(1, 0, 1);
        chk("R4 zero loads 65536", remaining, 65536);
        words(65535, 0);
        chk("R4 one left", remaining, 1);
        chk("R4 not done yet", count_done, 0);
        words(1, 0);
        chk("R4 full burst done", count_done, 1);
        chk("R4 full burst stop", stop_gen, 1);

        tick();
        summary();
    end
endmodule